// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block compares every memory access of a core against four programmable breakpoint slots. Each slot has an address register and a 4-bit field in the control register. The field selects which kind of access the slot watches and how many bytes it covers. Each slot also has a local and a global enable bit. When an access overlaps an armed slot's watched range and its kind agrees with the slot's setting, the slot's bit in the status register is set. The block then raises a single-cycle trap pulse.

Software reaches all registers through a plain indexed read/write port with a combinational read. A task-switch event clears every local enable in hardware and records itself in the status register. A single-step event is recorded the same way.

Top module: `bkpt_match_unit`

## Requirements
- R1: Register indices 0 to 3 hold the slot addresses and read back what was written. Index 6 is the status register and index 7 is the control register. Indices 4 and 5 read as 0, and writes to them change nothing.
- R2: Control bits 10 to 15 always read as 0. Every other control bit stores the written value, including bits 8 and 9, which have no other effect.
- R3: A task_switch pulse clears control bits 0, 2, 4 and 6 (the local enables). It leaves bits 1, 3, 5 and 7 (the global enables) unchanged. It sets status bit 15. When a control write and a task switch fall in the same cycle, the local enables still end up cleared.
- R4: Slot n is armed when control bit 2n (local) or bit 2n+1 (global) is 1. An unarmed slot never matches.
- R5: Slot n's kind field is control bits [17+4n:16+4n]: 00 matches only fetches, 01 only writes, 11 reads or writes, and 10 nothing. acc_kind encodes 00 fetch, 01 read, 10 write and 11 no access; kind 11 never matches.
- R6: Slot n's length field is control bits [19+4n:18+4n]: 00 means 1 byte, 01 means 2 bytes, 11 means 4 bytes and 10 means 8 bytes. The watched range starts at the slot address with its low log2(length) bits cleared.
- R7: An access covers the bytes acc_addr to acc_addr + 2^acc_size − 1. It matches a slot when that range shares at least one byte with the watched range.
- R8: A qualifying access while acc_valid is 1 sets status bit n of every matching slot at the next clock edge. In that same cycle trap_pulse is 1 for exactly one cycle per access, however many slots match.
- R9: Status bits 0 to 3 stay set until software writes 0 to them. When a hardware set and a software write to the status register fall in the same cycle, the set wins.
- R10: Status bits under mask 0xFFFF0FF0 always read as 1, whatever is written.
- R11: A step_event pulse sets status bit 14.
- R12: After reset the control register is 0, the slot addresses are 0, the status register reads 0xFFFF0FF0 and trap_pulse is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| acc_valid | input | 1 | Access present this cycle |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write, 11 none |
| acc_addr | input | 32 | Access start address |
| acc_size | input | 2 | log2 of access size in bytes |
| task_switch | input | 1 | Task-switch event pulse |
| step_event | input | 1 | Single-step event pulse |
| trap_pulse | output | 1 | One-cycle debug trap |

## Verification
Register reads are combinational, so a written value shows on reg_rdata one clock edge after the write strobe is sampled. An access presented in one cycle produces trap_pulse and the status bits right after the next rising edge. The bench drives inputs on falling edges and samples results on the following falling edge, exactly one register stage later. Task-switch and single-step effects follow the same one-edge rule and are read back through the register port. The reset state is checked only after the two-flop reset release has finished.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NSLOT = 4;
  localparam int DW    = 32;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_NONE  = 2'b11
  } acc_kind_e;

  localparam logic [1:0] WATCH_EXEC = 2'b00;
  localparam logic [1:0] WATCH_WR   = 2'b01;
  localparam logic [1:0] WATCH_RW   = 2'b11;

  localparam logic [2:0] IDX_STAT = 3'd6;
  localparam logic [2:0] IDX_CTRL = 3'd7;

  localparam logic [31:0] STAT_RSVD  = 32'hFFFF_0FF0;
  localparam logic [31:0] CTRL_WMASK = 32'hFFFF_03FF;
  localparam logic [7:0]  LOCAL_EN   = 8'h55;
  localparam int          STAT_STEP  = 14;
  localparam int          STAT_TSW   = 15;

  // length code to log2(bytes); the code is not monotonic
  function automatic logic [1:0] len_log2(input logic [1:0] code);
    case (code)
      2'b00:   len_log2 = 2'd0;
      2'b01:   len_log2 = 2'd1;
      2'b11:   len_log2 = 2'd2;
      default: len_log2 = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/bkpt_slot_cmp.sv
module bkpt_slot_cmp
  import bkpt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         armed,
  input  logic [1:0]   watch_kind,
  input  logic [1:0]   len_code,
  input  logic [W-1:0] slot_addr,
  input  logic         acc_valid,
  input  logic [1:0]   acc_kind,
  input  logic [W-1:0] acc_addr,
  input  logic [1:0]   acc_size,
  output logic         hit
);
  localparam int W1 = W + 1;

  logic [W:0] len_m1, sz_m1, w_lo, w_hi, a_lo, a_hi;
  logic       kind_ok, overlap;

  always_comb begin
    len_m1 = (W1'(1) << len_log2(len_code)) - W1'(1);
    sz_m1  = (W1'(1) << acc_size) - W1'(1);
    w_lo   = {1'b0, slot_addr & ~len_m1[W-1:0]};
    w_hi   = w_lo + len_m1;
    a_lo   = {1'b0, acc_addr};
    a_hi   = a_lo + sz_m1;
    overlap = (a_lo <= w_hi) && (w_lo <= a_hi);
    case (watch_kind)
      WATCH_EXEC: kind_ok = (acc_kind == KIND_FETCH);
      WATCH_WR:   kind_ok = (acc_kind == KIND_WRITE);
      WATCH_RW:   kind_ok = (acc_kind == KIND_READ) || (acc_kind == KIND_WRITE);
      default:    kind_ok = 1'b0;
    endcase
    hit = acc_valid & armed & kind_ok & overlap;
  end

  always_comb begin
    if (hit) begin
      AST_HIT_REAL_ACCESS: assert (acc_kind != KIND_NONE) else $error("hit on empty kind"); // R5
    end
  end
endmodule

// File: rtl/bkpt_status_reg.sv
module bkpt_status_reg
  import bkpt_pkg::*;
#(
  parameter int W  = 32,
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  input  logic [NS-1:0] hit_vec,
  input  logic          step_evt,
  input  logic          tsw_evt,
  output logic [W-1:0]  status_q
);
  logic [W-1:0] status_d, set_bits;
  logic         status_en;

  always_comb begin
    set_bits            = '0;
    set_bits[NS-1:0]    = hit_vec;
    set_bits[STAT_STEP] = step_evt;
    set_bits[STAT_TSW]  = tsw_evt;
    status_en = wr_en | (|hit_vec) | step_evt | tsw_evt;
    status_d  = (wr_en ? wdata : status_q) | set_bits | STAT_RSVD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= STAT_RSVD;
    else if (status_en) status_q <= status_d;
  end

  AST_RSVD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & STAT_RSVD) == STAT_RSVD) else $error("reserved status bit low"); // R10
  AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (($past(status_q[NS-1:0]) & ~status_q[NS-1:0]) == '0)) else $error("trap bit dropped"); // R9
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [2:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic         acc_valid,
  input  logic [1:0]   acc_kind,
  input  logic [31:0]  acc_addr,
  input  logic [1:0]   acc_size,
  input  logic         task_switch,
  input  logic         step_event,
  output logic         trap_pulse
);
  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic [W-1:0]     ctrl_q, ctrl_d, status_q;
  logic             ctrl_en;
  logic [W-1:0]     slot_q [NSLOT];
  logic [NSLOT-1:0] hit_vec;
  logic             trap_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  always_comb begin
    ctrl_en = task_switch | (reg_wr && reg_addr == IDX_CTRL);
    ctrl_d  = ctrl_q;
    if (reg_wr && reg_addr == IDX_CTRL) ctrl_d = reg_wdata & CTRL_WMASK;
    if (task_switch) ctrl_d[7:0] = ctrl_d[7:0] & ~LOCAL_EN;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic slot_we;
    assign slot_we = reg_wr && (reg_addr == 3'(s));

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s)     slot_q[s] <= '0;
      else if (slot_we) slot_q[s] <= reg_wdata;
    end

    bkpt_slot_cmp #(.W(W)) u_cmp (
      .armed      (ctrl_q[2*s] | ctrl_q[2*s+1]),
      .watch_kind (ctrl_q[16+4*s +: 2]),
      .len_code   (ctrl_q[18+4*s +: 2]),
      .slot_addr  (slot_q[s]),
      .acc_valid  (acc_valid),
      .acc_kind   (acc_kind),
      .acc_addr   (acc_addr),
      .acc_size   (acc_size),
      .hit        (hit_vec[s])
    );
  end

  bkpt_status_reg #(.W(W), .NS(NSLOT)) u_status (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (reg_wr && reg_addr == IDX_STAT),
    .wdata    (reg_wdata),
    .hit_vec  (hit_vec),
    .step_evt (step_event),
    .tsw_evt  (task_switch),
    .status_q (status_q)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) trap_q <= 1'b0;
    else          trap_q <= |hit_vec;
  end
  assign trap_pulse = trap_q;

  always_comb begin
    case (reg_addr)
      3'd0, 3'd1, 3'd2, 3'd3: reg_rdata = slot_q[reg_addr[1:0]];
      IDX_STAT:               reg_rdata = status_q;
      IDX_CTRL:               reg_rdata = ctrl_q;
      default:                reg_rdata = '0;
    endcase
  end

  AST_TSW_LOCAL_CLR: assert property (@(posedge clk) disable iff (!rst_n_s)
    task_switch |=> ((ctrl_q[7:0] & LOCAL_EN) == 8'h00)) else $error("local enable survived"); // R3
  AST_TSW_GLOBAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (task_switch && !(reg_wr && reg_addr == IDX_CTRL)) |=> ((ctrl_q[7:0] & ~LOCAL_EN) == ($past(ctrl_q[7:0]) & ~LOCAL_EN))) else $error("global enable lost"); // R3
  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    trap_pulse |-> (status_q[NSLOT-1:0] != '0)) else $error("trap without status"); // R8
  AST_PULSE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n_s)
    !acc_valid |=> !trap_pulse) else $error("trap without access"); // R8
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctrl_q[15:10] == 6'b0) else $error("reserved control bit set"); // R2
endmodule

// File: tb/tb_bkpt_match_unit.sv
module tb_bkpt_match_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = 2'b11;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = 2'd0;
  logic        task_switch = 1'b0;
  logic        step_event = 1'b0;
  logic        trap_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_match_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_size(acc_size),
    .task_switch(task_switch), .step_event(step_event), .trap_pulse(trap_pulse)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic access(input logic [1:0] k, input logic [31:0] a, input logic [1:0] s);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_addr = a; acc_size = s;
    @(negedge clk);
    acc_valid = 1'b0; acc_kind = 2'b11;
  endtask

  function automatic bit exp_hit(input logic [1:0] typ, input logic [1:0] lenc,
                                 input logic [31:0] sa, input logic [1:0] k,
                                 input logic [31:0] aa, input logic [1:0] s);
    longint unsigned lenb, wlo, whi, alo, ahi;
    bit kind_ok;
    lenb = (lenc == 2'b00) ? 1 : (lenc == 2'b01) ? 2 : (lenc == 2'b11) ? 4 : 8;
    wlo = longint'(sa) - (longint'(sa) % lenb);
    whi = wlo + lenb - 1;
    alo = longint'(aa);
    ahi = alo + (longint'(1) << s) - 1;
    case (typ)
      2'b00:   kind_ok = (k == 2'b00);
      2'b01:   kind_ok = (k == 2'b10);
      2'b11:   kind_ok = (k == 2'b01) || (k == 2'b10);
      default: kind_ok = 1'b0;
    endcase
    return kind_ok && (alo <= whi) && (wlo <= ahi);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    bit e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    rd(3'd7, r); chk(r == 32'h0, "R12 ctrl", r, 32'h0);
    rd(3'd6, r); chk(r == 32'hFFFF0FF0, "R12 status", r, 32'hFFFF0FF0);
    rd(3'd2, r); chk(r == 32'h0, "R12 slot", r, 32'h0);
    chk(trap_pulse == 1'b0, "R12 trap", {31'b0, trap_pulse}, 32'h0);

    // R1 register map
    for (int i = 0; i < 4; i++) wr(3'(i), 32'hA000_0000 + 32'(i * 16));
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), r); chk(r == 32'hA000_0000 + 32'(i * 16), "R1 slot readback", r, 32'hA000_0000 + 32'(i * 16));
    end
    wr(3'd4, 32'hDEAD_BEEF); wr(3'd5, 32'h1234_5678);
    rd(3'd4, r); chk(r == 32'h0, "R1 idx4", r, 32'h0);
    rd(3'd5, r); chk(r == 32'h0, "R1 idx5", r, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), r); chk(r == 32'hA000_0000 + 32'(i * 16), "R1 slot unchanged", r, 32'hA000_0000 + 32'(i * 16));
    end

    // R2 control storage
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, r); chk(r == 32'hFFFF_03FF, "R2 ctrl mask", r, 32'hFFFF_03FF);
    wr(3'd7, 32'h0000_0300);
    rd(3'd7, r); chk(r == 32'h0000_0300, "R2 slowdown bits", r, 32'h0000_0300);

    // R10 reserved status
    wr(3'd6, 32'h0);
    rd(3'd6, r); chk(r == 32'hFFFF0FF0, "R10 write zero", r, 32'hFFFF0FF0);
    wr(3'd6, 32'h0000_3000);
    rd(3'd6, r); chk(r == 32'hFFFF3FF0, "R10 bits12-13 stored", r, 32'hFFFF3FF0);
    wr(3'd6, 32'h0);

    // R6 R7 near-exhaustive sweep on slot 0, R/W kind, local enable
    for (int lc = 0; lc < 4; lc++) begin
      for (int a = 0; a < 8; a++) begin
        wr(3'd0, 32'h1000 + 32'(a));
        wr(3'd7, (32'(lc) << 18) | (32'h3 << 16) | 32'h1);
        for (int k = 0; k < 4; k++) begin
          for (int b = 0; b < 24; b++) begin
            for (int s = 0; s < 4; s++) begin
              access(2'(k), 32'h0FF8 + 32'(b), 2'(s));
              e = exp_hit(2'b11, 2'(lc), 32'h1000 + 32'(a), 2'(k), 32'h0FF8 + 32'(b), 2'(s));
              chk(trap_pulse == e, "R7 R6 trap", {31'b0, trap_pulse}, {31'b0, e});
              rd(3'd6, r);
              chk(r[0] == e, "R8 R6 status bit0", r, {31'b0, e});
              if (r[0]) wr(3'd6, 32'h0);
            end
          end
        end
      end
    end

    // R5 kind field sweep, exact address, 4-byte field on aligned word
    wr(3'd0, 32'h2000);
    for (int t = 0; t < 4; t++) begin
      wr(3'd7, (32'h3 << 18) | (32'(t) << 16) | 32'h2);
      for (int k = 0; k < 4; k++) begin
        access(2'(k), 32'h2000, 2'd2);
        e = exp_hit(2'(t), 2'b11, 32'h2000, 2'(k), 32'h2000, 2'd2);
        chk(trap_pulse == e, "R5 kind match", {29'b0, 1'(t), 2'(k)}, {31'b0, e});
        wr(3'd6, 32'h0);
      end
    end

    // R4 disarmed slot
    wr(3'd7, 32'h0003_0000);
    access(2'b01, 32'h2000, 2'd0);
    chk(trap_pulse == 1'b0, "R4 disarmed trap", {31'b0, trap_pulse}, 32'h0);
    rd(3'd6, r); chk(r == 32'hFFFF0FF0, "R4 disarmed status", r, 32'hFFFF0FF0);

    // R8 all four slots match at once, single pulse
    for (int i = 0; i < 4; i++) wr(3'(i), 32'h3000);
    wr(3'd7, 32'h3333_0099);
    access(2'b01, 32'h3000, 2'd0);
    chk(trap_pulse == 1'b1, "R8 multi trap", {31'b0, trap_pulse}, 32'h1);
    rd(3'd6, r); chk(r[3:0] == 4'hF, "R8 multi status", r, 32'hFFFF0FFF);
    @(negedge clk);
    chk(trap_pulse == 1'b0, "R8 single pulse", {31'b0, trap_pulse}, 32'h0);

    // R9 sticky, and set beats clear
    repeat (3) @(negedge clk);
    rd(3'd6, r); chk(r[3:0] == 4'hF, "R9 sticky", r, 32'hFFFF0FFF);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h0;
    acc_valid = 1'b1; acc_kind = 2'b10; acc_addr = 32'h3000; acc_size = 2'd0;
    @(negedge clk);
    reg_wr = 1'b0; acc_valid = 1'b0; acc_kind = 2'b11;
    rd(3'd6, r); chk(r[3:0] == 4'hF, "R9 set wins", r, 32'hFFFF0FFF);
    wr(3'd6, 32'h0);
    rd(3'd6, r); chk(r == 32'hFFFF0FF0, "R9 cleared", r, 32'hFFFF0FF0);

    // R11 step event
    @(negedge clk); step_event = 1'b1;
    @(negedge clk); step_event = 1'b0;
    rd(3'd6, r); chk(r == 32'hFFFF4FF0, "R11 step bit", r, 32'hFFFF4FF0);
    wr(3'd6, 32'h0);

    // R3 task switch
    wr(3'd7, 32'h3333_00FF);
    @(negedge clk); task_switch = 1'b1;
    @(negedge clk); task_switch = 1'b0;
    rd(3'd7, r); chk(r == 32'h3333_00AA, "R3 locals cleared", r, 32'h3333_00AA);
    rd(3'd6, r); chk(r == 32'hFFFF8FF0, "R3 status bit15", r, 32'hFFFF8FF0);
    wr(3'd6, 32'h0);
    wr(3'd7, 32'h3333_0055);
    @(negedge clk); task_switch = 1'b1;
    @(negedge clk); task_switch = 1'b0;
    access(2'b01, 32'h3000, 2'd0);
    chk(trap_pulse == 1'b0, "R3 local-only disarmed", {31'b0, trap_pulse}, 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd7; reg_wdata = 32'h3333_0003; task_switch = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; task_switch = 1'b0;
    rd(3'd7, r); chk(r == 32'h3333_0002, "R3 switch beats write", r, 32'h3333_0002);
    access(2'b10, 32'h3000, 2'd0);
    chk(trap_pulse == 1'b1, "R3 R4 global survives", {31'b0, trap_pulse}, 32'h1);
    rd(3'd6, r); chk(r[3:0] == 4'h1, "R3 slot0 only", r, 32'hFFFF8FF1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule